// File: doc/BRIEF.md
# Asynchronous Strobe Write Capture Front End

This block sits between an external memory bus and the internal storage engine. It watches the three active-low strobes: chip select, write enable and output enable. It first brings them into the clock domain through two-flop synchronizers. It then passes each one through a glitch filter, so a strobe counts as active only after it has stayed low for a parameterised number of clock cycles. A small state machine decides whether the bus is running a write cycle, a read cycle, or neither.

For a write, the address is captured when the second of chip select and write enable becomes active. The data is captured when the first of the two goes inactive. At that release a single-cycle write request carries the captured address and data to the programming engine. The block inhibits writes while output enable is active. It also inhibits writes while the digital supply-good input is low, and for a parameterised number of cycles after that input rises. For a read, the block sends a single-cycle read request with the address and raises a data-bus drive enable while the read condition lasts.

The state machine has four states. In ST_IDLE no cycle is in progress. ST_WRITE means a permitted write is open and its address has been captured. ST_READ means the bus is being driven. ST_WAIT means an inhibited or aborted write is waiting for its strobes to go inactive.

The transitions are:
- ST_IDLE to ST_WRITE when both write strobes become active and writing is permitted.
- ST_IDLE to ST_WAIT when both write strobes become active but writing is blocked.
- ST_IDLE to ST_READ on the read condition.
- ST_WRITE to ST_IDLE (commit) when either write strobe goes inactive.
- ST_WRITE to ST_WAIT (abort) when writing becomes blocked.
- ST_READ to ST_IDLE when the read condition ends.
- ST_WAIT to ST_IDLE once the two write strobes are no longer both active.

Top module: `bus_strobe_front`

## Requirements
- R1: While reset is asserted and on the first cycle after it, wr_req, rd_req and dout_en are 0.
- R2: A write request is a one-cycle pulse. It is raised exactly once per write cycle, on the cycle after the state machine sees one of the two active write strobes go inactive. It is raised only if output enable was inactive and writing was permitted for the whole cycle.
- R3: wr_addr carries the value of addr_in sampled when the later of chip select and write enable became active (after filtering). Later changes of addr_in during the cycle have no effect.
- R4: wr_data carries the value of data_in sampled when the earlier of the two write strobes became inactive.
- R5: A low pulse on a strobe that lasts fewer than GLITCH_CYC clock cycles is ignored. A low pulse of exactly GLITCH_CYC cycles is accepted.
- R6: Output enable active (oe_n = 0) blocks writes. If it becomes active while a write is open, the write is aborted without a request, and the abort takes priority over a commit in the same cycle.
- R7: No write request is made while supply_good is low, nor within PWR_DLY cycles after it rises, nor within PWR_DLY cycles after reset.
- R8: If both write strobes are already active when writing becomes permitted, no write starts. A new active edge of one of the strobes is required.
- R9: With chip select and output enable active and write enable inactive, rd_req pulses once with rd_addr = addr_in and dout_en is 1. In every other strobe combination dout_en is 0. dout_en and wr_req are never 1 together.
- R10: With chip select held active, each separate write enable pulse produces its own write request, carrying that pulse's address and data, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select strobe, active low, asynchronous |
| we_n | input | 1 | Write enable strobe, active low, asynchronous |
| oe_n | input | 1 | Output enable strobe, active low, asynchronous |
| supply_good | input | 1 | High when the supply is above the write threshold |
| addr_in | input | ADDR_W | Bus address |
| data_in | input | DATA_W | Bus write data |
| wr_req | output | 1 | One-cycle write request to the programming engine |
| wr_addr | output | ADDR_W | Address of the write request |
| wr_data | output | DATA_W | Data of the write request |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | ADDR_W | Address of the read request |
| dout_en | output | 1 | Drive enable for the data bus |

## Verification
The bench changes the address after both write strobes are seen active and changes the data just before the first release. A design that captured the address at the wrong edge, or the data at the last release or at the start of the cycle, would then report the wrong value. Strobe pulses of GLITCH_CYC-1 and of exactly GLITCH_CYC cycles probe the filter boundary, where an off-by-one counter either accepts glitches or drops legal pulses. The bench holds both strobes active across the end of the supply lockout, and it raises output enable in the middle of an open write. A state machine without the wait state would then commit a phantom write, and one that checked output enable only at the start would commit a write it should have aborted. A reference model run beside the design compares every output on every cycle, so a request one cycle early or late is also caught.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2,
        ST_WAIT  = 2'd3
    } fe_state_e;

    localparam int STB_CS  = 0;
    localparam int STB_WE  = 1;
    localparam int STB_OE  = 2;
    localparam int NUM_STB = 3;
endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
    parameter int   W       = 1,
    parameter logic RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= {W{RST_VAL}};
            q      <= {W{RST_VAL}};
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/sfe_filter.sv
module sfe_filter #(
    parameter int MIN_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_act,
    output logic out_act
);
    localparam int CW = $clog2(MIN_CYC + 1);
    localparam logic [CW-1:0] LIM = CW'(MIN_CYC);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              run_cnt <= '0;
        else if (!in_act)        run_cnt <= '0;
        else if (run_cnt != LIM) run_cnt <= run_cnt + 1'b1;
    end

    assign out_act = (run_cnt == LIM);

    AST_FILT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !in_act |=> !out_act); // R5
endmodule

// File: rtl/sfe_pwr_gate.sv
module sfe_pwr_gate #(
    parameter int DLY = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_good,
    output logic wr_allow
);
    localparam int CW = $clog2(DLY + 1);
    localparam logic [CW-1:0] LIM = CW'(DLY);

    logic          sup_s;
    logic [CW-1:0] up_cnt;

    sfe_sync #(.W(1), .RST_VAL(1'b0)) u_sup_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (supply_good),
        .q     (sup_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             up_cnt <= '0;
        else if (!sup_s)        up_cnt <= '0;
        else if (up_cnt != LIM) up_cnt <= up_cnt + 1'b1;
    end

    assign wr_allow = (up_cnt == LIM);

    AST_PWR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_s |=> !wr_allow); // R7
endmodule

// File: rtl/bus_strobe_front.sv
module bus_strobe_front
    import sfe_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int DATA_W     = 32,
    parameter int GLITCH_CYC = 3,
    parameter int PWR_DLY    = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              supply_good,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              dout_en
);
    logic [NUM_STB-1:0] raw_n;
    logic [NUM_STB-1:0] sync_n;
    logic [NUM_STB-1:0] act;
    logic               pwr_ok;

    assign raw_n[STB_CS] = cs_n;
    assign raw_n[STB_WE] = we_n;
    assign raw_n[STB_OE] = oe_n;

    sfe_sync #(.W(NUM_STB), .RST_VAL(1'b1)) u_stb_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_n),
        .q     (sync_n)
    );

    generate
        for (genvar i = 0; i < NUM_STB; i++) begin : g_filt
            sfe_filter #(.MIN_CYC(GLITCH_CYC)) u_filt (
                .clk     (clk),
                .rst_n   (rst_n),
                .in_act  (~sync_n[i]),
                .out_act (act[i])
            );
        end
    endgenerate

    sfe_pwr_gate #(.DLY(PWR_DLY)) u_pwr (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_good (supply_good),
        .wr_allow    (pwr_ok)
    );

    logic cs_a, we_a, oe_a;
    logic both_wr, wr_block, rd_cond;

    assign cs_a     = act[STB_CS];
    assign we_a     = act[STB_WE];
    assign oe_a     = act[STB_OE];
    assign both_wr  = cs_a & we_a;
    assign wr_block = oe_a | ~pwr_ok;
    assign rd_cond  = cs_a & oe_a & ~we_a;

    fe_state_e        state, nxt;
    logic [ADDR_W-1:0] cap_addr;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (both_wr)      nxt = wr_block ? ST_WAIT : ST_WRITE;
                else if (rd_cond) nxt = ST_READ;
            end
            ST_WRITE: begin
                if (wr_block)     nxt = ST_WAIT;
                else if (!both_wr) nxt = ST_IDLE;
            end
            ST_READ: begin
                if (!rd_cond)     nxt = ST_IDLE;
            end
            ST_WAIT: begin
                if (!both_wr)     nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_req   <= 1'b0;
            rd_req   <= 1'b0;
            cap_addr <= '0;
            wr_addr  <= '0;
            wr_data  <= '0;
            rd_addr  <= '0;
        end else begin
            wr_req <= 1'b0;
            rd_req <= 1'b0;
            if (state == ST_IDLE && nxt == ST_WRITE) begin
                cap_addr <= addr_in;
            end
            if (state == ST_WRITE && nxt == ST_IDLE) begin
                wr_req  <= 1'b1;
                wr_addr <= cap_addr;
                wr_data <= data_in;
            end
            if (state == ST_IDLE && nxt == ST_READ) begin
                rd_req  <= 1'b1;
                rd_addr <= addr_in;
            end
        end
    end

    assign dout_en = (state == ST_READ);

    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> !wr_req); // R2
    AST_WR_OE_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
        oe_a |=> !wr_req); // R6
    AST_WR_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> !wr_req); // R7
    AST_RD_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> dout_en); // R9
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_req && dout_en)); // R9
endmodule

// File: tb/bus_strobe_front_bench.sv
module bus_strobe_front_bench;
    localparam int AW = 17;
    localparam int DW = 32;
    localparam int GL = 3;
    localparam int PD = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic          supply_good = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic [DW-1:0] data_in = '0;
    logic          wr_req, rd_req, dout_en;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [DW-1:0] wr_data;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    bus_strobe_front #(
        .ADDR_W(AW), .DATA_W(DW), .GLITCH_CYC(GL), .PWR_DLY(PD)
    ) u_bus_strobe_front (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
        .supply_good(supply_good), .addr_in(addr_in), .data_in(data_in),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_req(rd_req), .rd_addr(rd_addr), .dout_en(dout_en)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference model: raw strobe history (1 = active), newest at the end.
    bit h_cs[$], h_we[$], h_oe[$], h_sup[$];
    int m_state = 0;  // 0 idle, 1 write open, 2 reading, 3 waiting
    bit m_wr = 0, m_rd = 0;
    logic [AW-1:0] m_cap = '0, m_waddr = '0, m_raddr = '0;
    logic [DW-1:0] m_wdata = '0;

    function automatic bit run_set(bit q[$], int first, int len);
        for (int k = first; k < first + len; k++) begin
            if (q.size() - 1 - k < 0) return 1'b0;
            if (!q[q.size() - 1 - k]) return 1'b0;
        end
        return 1'b1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_cs.delete(); h_we.delete(); h_oe.delete(); h_sup.delete();
            m_state = 0; m_wr = 0; m_rd = 0;
        end else begin
            bit c, w, o, p, both, blk, rdc;
            c = run_set(h_cs, 2, GL);
            w = run_set(h_we, 2, GL);
            o = run_set(h_oe, 2, GL);
            p = run_set(h_sup, 2, PD);
            both = c && w; blk = o || !p; rdc = c && o && !w;
            m_wr = 0; m_rd = 0;
            case (m_state)
                0: if (both) begin
                       if (blk) m_state = 3;
                       else begin m_state = 1; m_cap = addr_in; end
                   end else if (rdc) begin
                       m_state = 2; m_rd = 1; m_raddr = addr_in;
                   end
                1: if (blk) m_state = 3;
                   else if (!both) begin
                       m_state = 0; m_wr = 1; m_waddr = m_cap; m_wdata = data_in;
                   end
                2: if (!rdc) m_state = 0;
                default: if (!both) m_state = 0;
            endcase
            h_cs.push_back(!cs_n); h_we.push_back(!we_n);
            h_oe.push_back(!oe_n); h_sup.push_back(supply_good);
            if (h_sup.size() > 64) begin
                void'(h_cs.pop_front()); void'(h_we.pop_front());
                void'(h_oe.pop_front()); void'(h_sup.pop_front());
            end
        end
    end

    // Observation and per-cycle comparison, away from the active edge.
    logic [AW-1:0] obs_a[$];
    logic [DW-1:0] obs_d[$];
    int rd_seen = 0, dout_seen = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            check(wr_req === m_wr, "R2", "wr_req vs model", wr_req, m_wr);
            if (m_wr) begin
                check(wr_addr === m_waddr, "R3", "wr_addr vs model", wr_addr, m_waddr);
                check(wr_data === m_wdata, "R4", "wr_data vs model", wr_data, m_wdata);
            end
            check(rd_req === m_rd, "R9", "rd_req vs model", rd_req, m_rd);
            if (m_rd) check(rd_addr === m_raddr, "R9", "rd_addr vs model", rd_addr, m_raddr);
            check(dout_en === (m_state == 2), "R9", "dout_en vs model", dout_en, m_state == 2);
            check(!(wr_req && dout_en), "R9", "wr_req with dout_en", 1, 0);
            if (wr_req) begin obs_a.push_back(wr_addr); obs_d.push_back(wr_data); end
            if (rd_req) rd_seen++;
            if (dout_en) dout_seen++;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_obs();
        obs_a.delete(); obs_d.delete(); rd_seen = 0; dout_seen = 0;
    endtask

    // second strobe falls last and rises first; addr changes after capture,
    // data settles only just before the release
    task automatic wr_cycle(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input bit cs_last);
        addr_in = a; data_in = ~d;
        if (cs_last) we_n = 1'b0; else cs_n = 1'b0;
        cyc(3);
        if (cs_last) cs_n = 1'b0; else we_n = 1'b0;
        cyc(9);
        addr_in = ~a; data_in = d;
        cyc(3);
        if (cs_last) cs_n = 1'b1; else we_n = 1'b1;
        cyc(6);
        if (cs_last) we_n = 1'b1; else cs_n = 1'b1;
        cyc(8);
    endtask

    task automatic expect_writes(input int n, input string req);
        check(obs_a.size() == n, req, "write request count", obs_a.size(), n);
    endtask

    initial begin
        // R1: reset state
        cyc(3);
        check(wr_req === 1'b0 && rd_req === 1'b0 && dout_en === 1'b0, "R1",
              "outputs during reset", {wr_req, rd_req, dout_en}, 0);
        rst_n = 1'b1;
        cyc(1);
        check(wr_req === 1'b0 && rd_req === 1'b0 && dout_en === 1'b0, "R1",
              "outputs after reset", {wr_req, rd_req, dout_en}, 0);

        // R7: write inside the lockout window after reset
        clear_obs();
        cs_n = 0; we_n = 0; cyc(8); we_n = 1; cs_n = 1; cyc(8);
        expect_writes(0, "R7");
        cyc(50);

        // R2 R3 R4: write-enable controlled
        clear_obs();
        wr_cycle(17'h0_1234, 32'hCAFE_0001, 1'b0);
        expect_writes(1, "R2");
        if (obs_a.size() == 1) begin
            check(obs_a[0] == 17'h0_1234, "R3", "addr at later fall", obs_a[0], 17'h0_1234);
            check(obs_d[0] == 32'hCAFE_0001, "R4", "data at earlier rise", obs_d[0], 32'hCAFE_0001);
        end

        // R3 R4: chip-select controlled
        clear_obs();
        wr_cycle(17'h1_0F0F, 32'h1357_9BDF, 1'b1);
        expect_writes(1, "R2");
        if (obs_a.size() == 1) begin
            check(obs_a[0] == 17'h1_0F0F, "R3", "addr cs controlled", obs_a[0], 17'h1_0F0F);
            check(obs_d[0] == 32'h1357_9BDF, "R4", "data cs controlled", obs_d[0], 32'h1357_9BDF);
        end

        // R5: short pulse rejected, pulse of exactly GL accepted
        clear_obs();
        we_n = 0; cyc(3); cs_n = 0; cyc(GL - 1); cs_n = 1; cyc(8); we_n = 1; cyc(8);
        expect_writes(0, "R5");
        clear_obs();
        addr_in = 17'h0_0055;
        we_n = 0; cyc(3); cs_n = 0; cyc(GL); cs_n = 1; cyc(8); we_n = 1; cyc(8);
        expect_writes(1, "R5");

        // R6: oe held active, then oe during an open write
        clear_obs();
        oe_n = 0; cs_n = 0; we_n = 0; cyc(10); we_n = 1; cs_n = 1; cyc(6); oe_n = 1; cyc(8);
        expect_writes(0, "R6");
        clear_obs();
        cs_n = 0; we_n = 0; cyc(8); oe_n = 0; cyc(4); we_n = 1; cs_n = 1; cyc(6); oe_n = 1; cyc(8);
        expect_writes(0, "R6");

        // R7: supply low, just restored, then settled
        clear_obs();
        supply_good = 0; cyc(4);
        cs_n = 0; we_n = 0; cyc(8); we_n = 1; cs_n = 1; cyc(6);
        supply_good = 1;
        cs_n = 0; we_n = 0; cyc(8); we_n = 1; cs_n = 1; cyc(6);
        expect_writes(0, "R7");
        cyc(50);
        clear_obs();
        wr_cycle(17'h0_0777, 32'h0000_0777, 1'b0);
        expect_writes(1, "R7");

        // R8: strobes held across the end of the lockout
        clear_obs();
        supply_good = 0; cyc(4);
        cs_n = 0; we_n = 0; cyc(8);
        supply_good = 1; cyc(60);
        we_n = 1; cs_n = 1; cyc(8);
        expect_writes(0, "R8");

        // R10: page of write-enable pulses under one chip select
        clear_obs();
        cs_n = 0;
        for (int i = 0; i < 4; i++) begin
            addr_in = 17'h0_0100 + AW'(i); data_in = 32'hA000_0000 + DW'(i);
            we_n = 0; cyc(6); we_n = 1; cyc(6);
        end
        cs_n = 1; cyc(8);
        expect_writes(4, "R10");
        for (int i = 0; i < 4; i++) begin
            if (i < obs_a.size()) begin
                check(obs_a[i] == 17'h0_0100 + AW'(i), "R10", "page addr", obs_a[i], 17'h0_0100 + i);
                check(obs_d[i] == 32'hA000_0000 + DW'(i), "R10", "page data", obs_d[i], 32'hA000_0000 + i);
            end
        end

        // R9: read drives the bus, then floats
        clear_obs();
        addr_in = 17'h1_ABCD;
        cs_n = 0; oe_n = 0; cyc(12);
        check(dout_en === 1'b1, "R9", "dout_en during read", dout_en, 1);
        oe_n = 1; cyc(6);
        check(dout_en === 1'b0, "R9", "dout_en after oe off", dout_en, 0);
        check(rd_seen == 1, "R9", "read request count", rd_seen, 1);
        cs_n = 1; cyc(6);
        expect_writes(0, "R9");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(1_500_000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule